// File: doc/BRIEF.md
# Power Domain and Module Sleep Controller

This block gates the clock and reset of a set of peripheral modules. Each module sits in one power domain, and the block sequences changes to the module states. Software uses a 32-bit register bus. It first writes the requested next state of each module. Nothing changes at that point. The change is deferred until software issues a per-domain start command. The sequencer then keeps the domain busy for a fixed, parameterised number of cycles. At the end of that period it copies the requested states of every module in the domain into their live state. The live state drives the module clock-enable and reset outputs.

Domain 0 is on from reset and the other domains are off. If software starts a transition on an off domain while that domain's power-on request bit is set, the sequencer raises a per-domain power-switch request and stalls. It stays stalled until software writes the power-good acknowledge bit. The timed period then runs, and the domain reads as powered at its end. Module m belongs to domain m mod NUM_DOMAINS. The live level of each domain's external power-good input can be read back.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, no domain is busy and no power-switch request is pending. Domain 0 reads powered and every other domain reads off. Every module is in state 0, with its clock enable low and its reset output asserted (low).
- R2: A write to a module control register (0xA00 + 4*m) changes neither that module's status register (0x800 + 4*m) nor its outputs until a transition of its domain completes.
- R3: Writing 1 to bit d of the command register (0x120) makes bit d of the busy register (0x128) read 1 for exactly TRANS_CYCLES cycles, counted from the write edge, on a powered domain. At completion the state field of every module in domain d equals the code last written to its control register. Modules of other domains are unchanged.
- R4: A command to a domain that is already busy is ignored: the transition in progress is neither restarted nor lengthened.
- R5: A command to an off domain whose control register (0x300 + 4*d) has bit 0 set first sets bit d of the pending register (0x070) and drives ext_pwr_req_o[d] high. The domain stays busy for as long as bit 8 of that control register is 0. In the cycle after bit 8 is seen set, the pending bit clears. TRANS_CYCLES cycles later the transition completes and bit 0 of the domain status register (0x200 + 4*d) reads 1.
- R6: State codes are 0 = reset and clock off, 1 = synchronous reset with clock on, 2 = disabled (clock off, reset released), 3 = enabled (clock on, reset released). mod_clk_en_o is high in codes 1 and 3. mod_rst_n_o is high in codes 2 and 3. Module status bit 12 reads 1 exactly when the clock runs.
- R7: The state field occupies bits [4:0] of both module control and module status. Only codes 0 to 3 are kept: written bits [4:2] are dropped and read as 0, and all other bits read 0.
- R8: Reads of any unmapped or unaligned offset, and of the command register, return 0. Writes to unmapped offsets and to the read-only registers change no state.
- R9: Bit 1 of each domain status register follows that domain's pwr_good_i input.
- R10: A command to an off domain without a power-on request runs a plain timed transition that updates its modules and leaves the domain reading off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwr_good_i | input | NUM_DOMAINS | External power-good level per domain |
| ext_pwr_req_o | output | NUM_DOMAINS | Request to switch a domain's supply on |
| mod_clk_en_o | output | NUM_MODULES | Per-module clock enable |
| mod_rst_n_o | output | NUM_MODULES | Per-module active-low reset |

## Verification
The hardest situation to reach is the stalled power-up. It needs an off domain, an armed power-on request, a start command, and then a deliberately withheld acknowledge while further commands arrive. The bench builds this order directly. It first runs a plain transition on the off domain, then arms the request, issues the command, and waits many cycles. During the wait it repeats the command and checks that the domain stays pending and busy. It then writes the acknowledge and follows the pending bit and busy window cycle by cycle. Random module-state writes and commands then exercise both domains against a bench model.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  localparam logic [11:0] OFS_EXT_PEND   = 12'h070;
  localparam logic [11:0] OFS_GO         = 12'h120;
  localparam logic [11:0] OFS_BUSY       = 12'h128;
  localparam logic [11:0] OFS_DSTAT_BASE = 12'h200;
  localparam logic [11:0] OFS_DCTL_BASE  = 12'h300;
  localparam logic [11:0] OFS_MSTAT_BASE = 12'h800;
  localparam logic [11:0] OFS_MCTL_BASE  = 12'hA00;

  typedef enum logic [1:0] {
    MS_RST_OFF  = 2'd0,
    MS_SYNC_RST = 2'd1,
    MS_DISABLED = 2'd2,
    MS_ENABLED  = 2'd3
  } mod_state_e;

  typedef enum logic [1:0] {
    DS_IDLE    = 2'd0,
    DS_WAIT_PG = 2'd1,
    DS_RUN     = 2'd2
  } dom_fsm_e;

endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_sleep_pkg::*;
#(
  parameter int TRANS_CYCLES = 5,
  parameter bit RESET_ON     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic pwr_req_i,
  input  logic pwr_ack_i,
  output logic busy_o,
  output logic pend_o,
  output logic on_o,
  output logic done_o
);

  localparam int CW = $clog2(TRANS_CYCLES + 1);

  dom_fsm_e        state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            pwrup_q, pwrup_d;
  logic            on_q, on_d;
  logic            done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pwrup_d = pwrup_q;
    on_d    = on_q;
    done    = 1'b0;
    case (state_q)
      DS_IDLE: begin
        if (go_i) begin
          if (!on_q && pwr_req_i) begin
            state_d = DS_WAIT_PG;
            pwrup_d = 1'b1;
          end else begin
            state_d = DS_RUN;
            cnt_d   = CW'(TRANS_CYCLES);
            pwrup_d = 1'b0;
          end
        end
      end
      DS_WAIT_PG: begin
        if (pwr_ack_i) begin
          state_d = DS_RUN;
          cnt_d   = CW'(TRANS_CYCLES);
        end
      end
      DS_RUN: begin
        if (cnt_q == CW'(1)) begin
          state_d = DS_IDLE;
          done    = 1'b1;
          pwrup_d = 1'b0;
          if (pwrup_q) on_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      cnt_q   <= '0;
      pwrup_q <= 1'b0;
      on_q    <= RESET_ON;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pwrup_q <= pwrup_d;
      on_q    <= on_d;
    end
  end

  assign busy_o = (state_q != DS_IDLE);
  assign pend_o = (state_q == DS_WAIT_PG);
  assign on_o   = on_q;
  assign done_o = done;

  a_r5_pend_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> busy_o);

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r10_power_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    on_o |=> on_o);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TRANS_CYCLES));

  a_r5_pend_clears_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && pwr_ack_i) |=> !pend_o);

endmodule

// File: rtl/pwr_mod_state.sv
module pwr_mod_state
  import pwr_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply_i,
  input  logic [1:0] next_i,
  output logic [1:0] state_o,
  output logic       clk_en_o,
  output logic       rst_n_o
);

  mod_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (apply_i) state_d = mod_state_e'(next_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_RST_OFF;
    else        state_q <= state_d;
  end

  assign state_o  = state_q;
  assign clk_en_o = (state_q == MS_SYNC_RST) || (state_q == MS_ENABLED);
  assign rst_n_o  = (state_q == MS_DISABLED) || (state_q == MS_ENABLED);

  a_r2_hold_without_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(state_o));

  a_r3_apply_takes_next: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (state_o == $past(next_i)));

endmodule

// File: rtl/pwr_bus_decode.sv
module pwr_bus_decode
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 6
) (
  input  logic [11:0]                  addr_i,
  input  logic                         wr_i,
  input  logic [NUM_DOMAINS-1:0]       go_bits_i,
  input  logic [NUM_DOMAINS-1:0]       pend_i,
  input  logic [NUM_DOMAINS-1:0]       busy_i,
  input  logic [NUM_DOMAINS-1:0]       on_i,
  input  logic [NUM_DOMAINS-1:0]       pg_i,
  input  logic [NUM_DOMAINS-1:0]       dreq_i,
  input  logic [NUM_DOMAINS-1:0]       dack_i,
  input  logic [NUM_MODULES-1:0][1:0]  mctl_i,
  input  logic [NUM_MODULES-1:0][1:0]  mstate_i,
  output logic [NUM_DOMAINS-1:0]       go_wr_o,
  output logic [NUM_DOMAINS-1:0]       dctl_we_o,
  output logic [NUM_MODULES-1:0]       mctl_we_o,
  output logic [31:0]                  rdata_o
);

  assign go_wr_o = (wr_i && addr_i == OFS_GO) ? go_bits_i : '0;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom_we
    assign dctl_we_o[d] = wr_i && (addr_i == OFS_DCTL_BASE + 12'(4 * d));
  end

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod_we
    assign mctl_we_o[m] = wr_i && (addr_i == OFS_MCTL_BASE + 12'(4 * m));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_EXT_PEND) rdata_o[NUM_DOMAINS-1:0] = pend_i;
    if (addr_i == OFS_BUSY)     rdata_o[NUM_DOMAINS-1:0] = busy_i;
    for (int d = 0; d < NUM_DOMAINS; d++) begin
      if (addr_i == OFS_DSTAT_BASE + 12'(4 * d))
        rdata_o = {30'b0, pg_i[d], on_i[d]};
      if (addr_i == OFS_DCTL_BASE + 12'(4 * d))
        rdata_o = {23'b0, dack_i[d], 7'b0, dreq_i[d]};
    end
    for (int m = 0; m < NUM_MODULES; m++) begin
      if (addr_i == OFS_MSTAT_BASE + 12'(4 * m))
        rdata_o = {19'b0, mstate_i[m][0], 10'b0, mstate_i[m]};
      if (addr_i == OFS_MCTL_BASE + 12'(4 * m))
        rdata_o = {30'b0, mctl_i[m]};
    end
  end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_DOMAINS  = 2,
  parameter int NUM_MODULES  = 6,
  parameter int TRANS_CYCLES = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [11:0]            bus_addr,
  input  logic                   bus_wr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_DOMAINS-1:0] pwr_good_i,
  output logic [NUM_DOMAINS-1:0] ext_pwr_req_o,
  output logic [NUM_MODULES-1:0] mod_clk_en_o,
  output logic [NUM_MODULES-1:0] mod_rst_n_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_DOMAINS-1:0]      go_wr, dctl_we, busy, pend, on, done;
  logic [NUM_DOMAINS-1:0]      dreq_q, dack_q;
  logic [NUM_MODULES-1:0]      mctl_we;
  logic [NUM_MODULES-1:0][1:0] mctl_q, mstate;
  logic                        unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:9], bus_wdata[7:2]};

  pwr_bus_decode #(
    .NUM_DOMAINS(NUM_DOMAINS),
    .NUM_MODULES(NUM_MODULES)
  ) u_decode (
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .go_bits_i (bus_wdata[NUM_DOMAINS-1:0]),
    .pend_i    (pend),
    .busy_i    (busy),
    .on_i      (on),
    .pg_i      (pwr_good_i),
    .dreq_i    (dreq_q),
    .dack_i    (dack_q),
    .mctl_i    (mctl_q),
    .mstate_i  (mstate),
    .go_wr_o   (go_wr),
    .dctl_we_o (dctl_we),
    .mctl_we_o (mctl_we),
    .rdata_o   (bus_rdata)
  );

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    logic req_d, ack_d;

    always_comb begin
      req_d = dreq_q[d];
      ack_d = dack_q[d];
      if (dctl_we[d]) begin
        req_d = bus_wdata[0];
        ack_d = bus_wdata[8];
      end
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) begin
        dreq_q[d] <= 1'b0;
        dack_q[d] <= 1'b0;
      end else begin
        dreq_q[d] <= req_d;
        dack_q[d] <= ack_d;
      end
    end

    pwr_dom_seq #(
      .TRANS_CYCLES(TRANS_CYCLES),
      .RESET_ON    (d == 0)
    ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .go_i      (go_wr[d]),
      .pwr_req_i (dreq_q[d]),
      .pwr_ack_i (dack_q[d]),
      .busy_o    (busy[d]),
      .pend_o    (pend[d]),
      .on_o      (on[d]),
      .done_o    (done[d])
    );

    a_r4_busy_starts_on_go: assert property (@(posedge clk) disable iff (!rst_n_int)
      $rose(busy[d]) |-> $past(go_wr[d]));
  end

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    localparam int DOM = m % NUM_DOMAINS;
    logic [1:0] ctl_d;

    always_comb begin
      ctl_d = mctl_q[m];
      if (mctl_we[m]) ctl_d = bus_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) mctl_q[m] <= 2'b00;
      else            mctl_q[m] <= ctl_d;
    end

    pwr_mod_state u_state (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .apply_i  (done[DOM]),
      .next_i   (mctl_q[m]),
      .state_o  (mstate[m]),
      .clk_en_o (mod_clk_en_o[m]),
      .rst_n_o  (mod_rst_n_o[m])
    );
  end

  assign ext_pwr_req_o = pend;

endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb;
  localparam int ND = 2;
  localparam int NM = 6;
  localparam int TC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [ND-1:0] pwr_good_i = '0;
  logic [ND-1:0] ext_pwr_req_o;
  logic [NM-1:0] mod_clk_en_o, mod_rst_n_o;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl #(.NUM_DOMAINS(ND), .NUM_MODULES(NM), .TRANS_CYCLES(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_good_i(pwr_good_i),
    .ext_pwr_req_o(ext_pwr_req_o), .mod_clk_en_o(mod_clk_en_o), .mod_rst_n_o(mod_rst_n_o)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;
  logic [1:0] exp_ctl [NM];
  logic [1:0] exp_st  [NM];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] mstat_exp(input logic [1:0] s);
    return {19'b0, s[0], 10'b0, s};
  endfunction

  function automatic logic [11:0] mofs(input int base, input int m);
    return 12'(base + 4 * m);
  endfunction

  task automatic check_mods(input string req);
    logic [31:0] v;
    for (int m = 0; m < NM; m++) begin
      rd(mofs(12'h800, m), v);
      check({req, " mod status"}, v, mstat_exp(exp_st[m]));
      rd(mofs(12'hA00, m), v);
      check({req, "/R7 mod ctl readback"}, v, {30'b0, exp_ctl[m]});
      check({req, "/R6 clk_en"}, 32'(mod_clk_en_o[m]), 32'(exp_st[m][0]));
      check({req, "/R6 rst_n"}, 32'(mod_rst_n_o[m]), 32'(exp_st[m][1]));
    end
  endtask

  task automatic count_busy(input int d, output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(12'h128, v);
      if (!v[d]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic apply_dom(input int d);
    for (int m = 0; m < NM; m++) if (m % ND == d) exp_st[m] = exp_ctl[m];
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int unsigned r;
    void'($urandom(32'h5EED_1234));
    for (int m = 0; m < NM; m++) begin exp_ctl[m] = 2'd0; exp_st[m] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h128, v); check("R1 busy", v, 32'h0);
    rd(12'h070, v); check("R1 pending", v, 32'h0);
    check("R1 ext req", 32'(ext_pwr_req_o), 32'h0);
    rd(12'h200, v); check("R1 dom0 on", v, 32'h1);
    rd(12'h204, v); check("R1 dom1 off", v, 32'h0);
    check_mods("R1");

    // R9 power-good visible
    pwr_good_i = 2'b10;
    rd(12'h204, v); check("R9 dom1 pg", v, 32'h2);
    rd(12'h200, v); check("R9 dom0 no pg", v, 32'h1);
    pwr_good_i = 2'b00;
    rd(12'h204, v); check("R9 dom1 pg low", v, 32'h0);

    // R2 deferred writes, R7 field trimming
    for (int m = 0; m < NM; m++) begin
      wr(mofs(12'hA00, m), 32'(m % 4));
      exp_ctl[m] = 2'(m % 4);
    end
    wr(mofs(12'hA00, 2), 32'hFFFF_FFFE);
    exp_ctl[2] = 2'd2;
    repeat (3) @(negedge clk);
    check_mods("R2");

    // R3 timed transition on domain 0
    wr(12'h120, 32'h1);
    count_busy(0, n);
    check("R3 busy window", 32'(n), 32'(TC));
    apply_dom(0);
    check_mods("R3");

    // R4 repeated GO while running
    wr(mofs(12'hA00, 0), 32'h1); exp_ctl[0] = 2'd1;
    wr(12'h120, 32'h1);
    wr(12'h120, 32'h1);
    count_busy(0, n);
    check("R4 no restart", 32'(n), 32'(TC - 2));
    apply_dom(0);
    check_mods("R4");

    // R10 off domain without power request
    wr(12'h120, 32'h2);
    count_busy(1, n);
    check("R10 busy window", 32'(n), 32'(TC));
    rd(12'h204, v); check("R10 dom1 still off", v, 32'h0);
    apply_dom(1);
    check_mods("R10");

    // R5 power-up handshake
    wr(mofs(12'hA00, 1), 32'h3); exp_ctl[1] = 2'd3;
    wr(mofs(12'hA00, 5), 32'h2); exp_ctl[5] = 2'd2;
    wr(12'h304, 32'h1);
    rd(12'h304, v); check("R5 dctl req readback", v, 32'h1);
    wr(12'h120, 32'h2);
    rd(12'h070, v); check("R5 pending set", v, 32'h2);
    check("R5 ext req", 32'(ext_pwr_req_o), 32'h2);
    repeat (20) @(negedge clk);
    rd(12'h070, v); check("R5 still pending", v, 32'h2);
    rd(12'h128, v); check("R5 still busy", v, 32'h2);
    wr(12'h120, 32'h2);
    rd(12'h070, v); check("R4 GO during stall ignored", v, 32'h2);
    check_mods("R5 stalled");
    wr(12'h304, 32'h101);
    rd(12'h070, v); check("R5 pending one cycle after ack", v, 32'h2);
    @(negedge clk);
    rd(12'h070, v); check("R5 pending cleared", v, 32'h0);
    check("R5 ext req cleared", 32'(ext_pwr_req_o), 32'h0);
    count_busy(1, n);
    check("R5 busy after ack", 32'(n), 32'(TC));
    rd(12'h204, v); check("R5 dom1 on", v, 32'h1);
    apply_dom(1);
    check_mods("R5");

    // R8 unmapped and read-only
    rd(12'h120, v); check("R8 GO reads zero", v, 32'h0);
    rd(12'h000, v); check("R8 unmapped 0x000", v, 32'h0);
    rd(12'h123, v); check("R8 unaligned", v, 32'h0);
    rd(mofs(12'h200, ND), v); check("R8 dstat past end", v, 32'h0);
    rd(mofs(12'h800, NM), v); check("R8 mstat past end", v, 32'h0);
    wr(mofs(12'hA00, NM), 32'hFFFF_FFFF);
    wr(12'hA01, 32'hFFFF_FFFF);
    wr(12'h128, 32'hFFFF_FFFF);
    wr(12'h070, 32'hFFFF_FFFF);
    wr(12'h804, 32'hFFFF_FFFF);
    rd(mofs(12'hA00, NM), v); check("R8 mctl past end", v, 32'h0);
    rd(12'h128, v); check("R8 busy untouched", v, 32'h0);
    rd(12'h070, v); check("R8 pending untouched", v, 32'h0);
    check_mods("R8");

    // R3/R6 random mix
    for (int it = 0; it < 40; it++) begin
      int m, d;
      m = int'($urandom % NM);
      r = $urandom;
      wr(mofs(12'hA00, m), r);
      exp_ctl[m] = r[1:0];
      if ($urandom % 3 == 0) begin
        d = int'($urandom % ND);
        wr(12'h120, 32'(1 << d));
        count_busy(d, n);
        check("R3 random busy window", 32'(n), 32'(TC));
        apply_dom(d);
      end
      check_mods("R6 random");
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule